// File: doc/BRIEF.md
# Isochronous IN Endpoint DMA Request Controller

This block decides, for every physical endpoint of a device-side USB controller, when the memory-transfer engine must refill an isochronous IN buffer. On each frame tick it raises a request flag for every endpoint that is isochronous and placed in DMA mode. It does this whether or not the host sent an IN token during that frame. A raised request is served only when the endpoint's DMA path is enabled and a transfer descriptor is ready. In that case the block issues a fetch strobe, which loads the next frame's data into the endpoint buffer. The request flag then falls back to zero, so the next tick can fire again.

When a request finds no usable descriptor, the block gives no response and the flag stays at one. Later ticks are then ignored for that endpoint. Requests are edge triggered, so software must clear the flag to re-arm the endpoint. If a previous transfer never completed (the host dropped the transaction), the next served request also issues a flush strobe, and the stale buffer contents are discarded with no software action. When the packet engine reports a completed transfer, a sticky end-of-transfer flag is set. This flag is cleared by writing a one, and it feeds a masked interrupt line. Serving a request raises no interrupt.

Top module: `isoDmaReq`

## Requirements
- R1: A frame tick sets bit i of `reqStatus` (bit i = endpoint i) when bit i is set in both `ISO_EP_MASK` (default 0xFFFF_FFF0, so endpoints 0 to 3 are not isochronous) and `dmaModeSel`. This happens regardless of transfer activity. No other bit is raised.
- R2: Requests are edge triggered. While bit i is already 1, a frame tick produces neither a new request nor a fetch for endpoint i.
- R3: If the descriptor for endpoint i is not valid on the cycle after the tick that raised its request, no fetch is issued, and bit i stays 1 until it is cleared.
- R4: A one in bit i of `reqClr` clears request bit i after the edge. Zero bits have no effect. A cleared endpoint fires again on the next frame tick.
- R5: When `reqClr` bit i and a frame tick occur in the same cycle, the clear wins: bit i is 0 after the edge.
- R6: With `descValid` and `dmaEnable` set, `fetchStrobe` bit i pulses for one cycle, one edge after the edge that raised the request. `reqStatus` bit i returns to 0 on that same edge. No end-of-transfer flag is set.
- R7: A served request on an endpoint whose previous fetch has not seen `xferDone` also pulses `flushStrobe` bit i together with `fetchStrobe`.
- R8: `xferDone` bit i sets sticky `eotFlag` bit i only when endpoint i has an outstanding fetch. The flag is not set otherwise.
- R9: A one in bit i of `eotClr` clears `eotFlag` bit i. `eotIrq` is the OR of `eotFlag & eotMask`.
- R10: A one in bit i of `reqSet` sets request bit i without causing a fetch. Zero bits have no effect. If set and clear arrive together, clear wins.
- R11: An endpoint whose `dmaEnable` bit is 0 is never fetched. Its raised request stays latched at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameTick | input | 1 | One-cycle strobe at each frame start |
| dmaModeSel | input | NUM_EP | Per-endpoint DMA-mode select for the request logic |
| dmaEnable | input | NUM_EP | Per-endpoint DMA path enable |
| descValid | input | NUM_EP | Descriptor ready for the endpoint |
| xferDone | input | NUM_EP | Transfer-complete pulse from the packet engine |
| reqSet | input | NUM_EP | Write-1-to-set pulse for request bits |
| reqClr | input | NUM_EP | Write-1-to-clear pulse for request bits |
| eotClr | input | NUM_EP | Write-1-to-clear pulse for end-of-transfer flags |
| eotMask | input | NUM_EP | Interrupt mask for end-of-transfer flags |
| reqStatus | output | NUM_EP | Request status flags |
| fetchStrobe | output | NUM_EP | Descriptor fetch / buffer load strobe |
| flushStrobe | output | NUM_EP | Stale buffer discard strobe |
| eotFlag | output | NUM_EP | Sticky end-of-transfer flags |
| eotIrq | output | 1 | Masked end-of-transfer interrupt |

## Verification
The two functions that collide are the software clear of a request bit and the frame tick that would raise that same bit. The bench provokes this directly: it drives `reqClr` on endpoint 6 in the cycle of a tick while endpoint 5 ticks normally. It then checks that bit 6 reads 0 and is never fetched, while endpoint 5 is raised and fetched one edge later. Random traffic keeps overlapping ticks, clears, sets and completions across all 32 endpoints. Every cycle is compared against a bench model of the requirements, so the same-cycle cases are judged bit by bit.

// File: rtl/isoDmaPkg.sv
package isoDmaPkg;
  // Per-endpoint decisions handed from control to the register datapath.
  typedef struct packed {
    logic raise;     // frame tick accepted as a new request
    logic service;   // request served: load buffer
    logic complete;  // outstanding transfer finished
    logic drop;      // stale buffer discarded on service
  } epStrobe_t;
endpackage

// File: rtl/isoReqCtrl.sv
module isoReqCtrl
  import isoDmaPkg::*;
#(
  parameter int unsigned NUM_EP = 32,
  parameter logic [NUM_EP-1:0] ISO_EP_MASK = '1
) (
  input  logic frameTick,
  input  logic [NUM_EP-1:0] dmaModeSel,
  input  logic [NUM_EP-1:0] dmaEnable,
  input  logic [NUM_EP-1:0] descValid,
  input  logic [NUM_EP-1:0] reqClr,
  input  logic [NUM_EP-1:0] xferDone,
  input  logic [NUM_EP-1:0] reqQ,
  input  logic [NUM_EP-1:0] newReqQ,
  input  logic [NUM_EP-1:0] activeQ,
  output epStrobe_t [NUM_EP-1:0] strb
);
  for (genvar ep = 0; ep < NUM_EP; ep++) begin : g_ep
    logic armed;
    assign armed = ISO_EP_MASK[ep] & dmaModeSel[ep];
    always_comb begin
      strb[ep].raise    = frameTick & armed & ~reqQ[ep] & ~reqClr[ep];
      strb[ep].service  = newReqQ[ep] & reqQ[ep] & dmaEnable[ep]
                          & descValid[ep] & ~reqClr[ep];
      strb[ep].complete = xferDone[ep] & activeQ[ep];
      strb[ep].drop     = strb[ep].service & activeQ[ep] & ~xferDone[ep];
    end
  end
endmodule

// File: rtl/isoReqRegs.sv
module isoReqRegs
  import isoDmaPkg::*;
#(
  parameter int unsigned NUM_EP = 32
) (
  input  logic clk,
  input  logic rstN,
  input  epStrobe_t [NUM_EP-1:0] strb,
  input  logic [NUM_EP-1:0] reqSet,
  input  logic [NUM_EP-1:0] reqClr,
  input  logic [NUM_EP-1:0] eotClr,
  output logic [NUM_EP-1:0] reqQ,
  output logic [NUM_EP-1:0] newReqQ,
  output logic [NUM_EP-1:0] activeQ,
  output logic [NUM_EP-1:0] eotQ,
  output logic [NUM_EP-1:0] fetchQ,
  output logic [NUM_EP-1:0] flushQ
);
  logic [NUM_EP-1:0] svcV;

  for (genvar ep = 0; ep < NUM_EP; ep++) begin : g_ep
    assign svcV[ep] = strb[ep].service;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        reqQ[ep]    <= 1'b0;
        newReqQ[ep] <= 1'b0;
        activeQ[ep] <= 1'b0;
        eotQ[ep]    <= 1'b0;
        fetchQ[ep]  <= 1'b0;
        flushQ[ep]  <= 1'b0;
      end else begin
        if (reqClr[ep])
          reqQ[ep] <= 1'b0;
        else
          reqQ[ep] <= (reqQ[ep] & ~strb[ep].service) | strb[ep].raise | reqSet[ep];
        newReqQ[ep] <= strb[ep].raise;
        if (strb[ep].service)       activeQ[ep] <= 1'b1;
        else if (strb[ep].complete) activeQ[ep] <= 1'b0;
        eotQ[ep]   <= (eotQ[ep] & ~eotClr[ep]) | strb[ep].complete;
        fetchQ[ep] <= strb[ep].service;
        flushQ[ep] <= strb[ep].drop;
      end
    end
  end

  // R3: a request bit only falls through a clear or a service.
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    1 |=> ((($past(reqQ) & ~$past(reqClr) & ~$past(svcV)) & ~reqQ) == '0));
  // R5: a cleared bit reads zero after the edge.
  assert_clr_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|reqClr) |=> ((reqQ & $past(reqClr)) == '0));
  // R2: a fetch only follows a freshly raised request.
  assert_fetch_edge_R2: assert property (@(posedge clk) disable iff (!rstN)
    1 |=> ((fetchQ & ~$past(newReqQ)) == '0));
  // R7: a flush never appears without a fetch.
  assert_flush_fetch_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((flushQ & ~fetchQ) == '0));
  // R8: end-of-transfer only rises on an outstanding transfer.
  assert_eot_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    1 |=> ((eotQ & ~$past(eotQ) & ~$past(activeQ)) == '0));
  // R9: end-of-transfer falls only on its own clear.
  assert_eot_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    1 |=> ((~eotQ & $past(eotQ) & ~$past(eotClr)) == '0));
endmodule

// File: rtl/isoDmaReq.sv
module isoDmaReq
  import isoDmaPkg::*;
#(
  parameter int unsigned NUM_EP = 32,
  parameter logic [NUM_EP-1:0] ISO_EP_MASK = 32'hFFFF_FFF0
) (
  input  logic clk,
  input  logic rstN,
  input  logic frameTick,
  input  logic [NUM_EP-1:0] dmaModeSel,
  input  logic [NUM_EP-1:0] dmaEnable,
  input  logic [NUM_EP-1:0] descValid,
  input  logic [NUM_EP-1:0] xferDone,
  input  logic [NUM_EP-1:0] reqSet,
  input  logic [NUM_EP-1:0] reqClr,
  input  logic [NUM_EP-1:0] eotClr,
  input  logic [NUM_EP-1:0] eotMask,
  output logic [NUM_EP-1:0] reqStatus,
  output logic [NUM_EP-1:0] fetchStrobe,
  output logic [NUM_EP-1:0] flushStrobe,
  output logic [NUM_EP-1:0] eotFlag,
  output logic eotIrq
);
  epStrobe_t [NUM_EP-1:0] strb;
  logic [NUM_EP-1:0] reqQ, newReqQ, activeQ, eotQ, fetchQ, flushQ;

  isoReqCtrl #(.NUM_EP(NUM_EP), .ISO_EP_MASK(ISO_EP_MASK)) u_ctrl (
    .frameTick(frameTick), .dmaModeSel(dmaModeSel), .dmaEnable(dmaEnable),
    .descValid(descValid), .reqClr(reqClr), .xferDone(xferDone),
    .reqQ(reqQ), .newReqQ(newReqQ), .activeQ(activeQ), .strb(strb)
  );

  isoReqRegs #(.NUM_EP(NUM_EP)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .reqSet(reqSet), .reqClr(reqClr),
    .eotClr(eotClr), .reqQ(reqQ), .newReqQ(newReqQ), .activeQ(activeQ),
    .eotQ(eotQ), .fetchQ(fetchQ), .flushQ(flushQ)
  );

  assign reqStatus   = reqQ;
  assign fetchStrobe = fetchQ;
  assign flushStrobe = flushQ;
  assign eotFlag     = eotQ;
  assign eotIrq      = |(eotQ & eotMask);

  // R1: a request bit can only rise on an isochronous endpoint or by a set.
  assert_iso_only_R1: assert property (@(posedge clk) disable iff (!rstN)
    1 |=> ((reqStatus & ~$past(reqStatus) & ~ISO_EP_MASK & ~$past(reqSet)) == '0));
  // R11: no fetch on an endpoint with its DMA path disabled.
  assert_dma_gate_R11: assert property (@(posedge clk) disable iff (!rstN)
    1 |=> ((fetchStrobe & ~$past(dmaEnable)) == '0));
endmodule

// File: tb/test_isoDmaReq.sv
module test_isoDmaReq;
  localparam int N = 32;
  localparam logic [N-1:0] ISO = 32'hFFFF_FFF0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameTick = 1'b0;
  logic [N-1:0] dmaModeSel = '1, dmaEnable = '1, descValid = '0, xferDone = '0;
  logic [N-1:0] reqSet = '0, reqClr = '0, eotClr = '0, eotMask = '0;
  logic [N-1:0] reqStatus, fetchStrobe, flushStrobe, eotFlag;
  logic eotIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  isoDmaReq i_isoDmaReq (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .dmaModeSel(dmaModeSel),
    .dmaEnable(dmaEnable), .descValid(descValid), .xferDone(xferDone),
    .reqSet(reqSet), .reqClr(reqClr), .eotClr(eotClr), .eotMask(eotMask),
    .reqStatus(reqStatus), .fetchStrobe(fetchStrobe), .flushStrobe(flushStrobe),
    .eotFlag(eotFlag), .eotIrq(eotIrq)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  // bench model state
  logic [N-1:0] mReq, mNew, mAct, mEot, mFetch, mFlush;

  function automatic void modelStep();
    logic [N-1:0] nReq, nNew, nAct, nEot;
    for (int i = 0; i < N; i++) begin
      bit armed, raised, served, done;
      armed  = ISO[i] && dmaModeSel[i];
      raised = frameTick && armed && !mReq[i] && !reqClr[i];
      served = mNew[i] && mReq[i] && dmaEnable[i] && descValid[i] && !reqClr[i];
      done   = xferDone[i] && mAct[i];
      mFetch[i] = served;
      mFlush[i] = served && mAct[i] && !done;
      nNew[i] = raised;
      if (reqClr[i]) nReq[i] = 1'b0;
      else if (reqSet[i] || raised) nReq[i] = 1'b1;
      else if (served) nReq[i] = 1'b0;
      else nReq[i] = mReq[i];
      nAct[i] = served ? 1'b1 : (done ? 1'b0 : mAct[i]);
      nEot[i] = done ? 1'b1 : (eotClr[i] ? 1'b0 : mEot[i]);
    end
    mReq = nReq; mNew = nNew; mAct = nAct; mEot = nEot;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("reset reqStatus R1", reqStatus, '0);
    chk("reset fetch R6", fetchStrobe, '0);
    chk("reset flush R7", flushStrobe, '0);
    chk("reset eot R8", eotFlag, '0);
    chk("reset irq R9", {31'd0, eotIrq}, '0);
    rstN = 1'b1;
    cyc();

    // no descriptor: request latches
    frameTick = 1; cyc(); frameTick = 0;
    chk("R1 tick raises iso endpoints", reqStatus, 32'hFFFF_FFF0);
    cyc();
    chk("R3 no fetch without descriptor", fetchStrobe, '0);
    chk("R3 request stays latched", reqStatus, 32'hFFFF_FFF0);
    frameTick = 1; cyc(); frameTick = 0; cyc();
    chk("R2 latched bit ignores later tick", fetchStrobe, '0);

    // clear re-arms ep5, valid descriptor serves it
    reqClr = 32'h20; cyc(); reqClr = '0;
    chk("R4 clear only selected bit", reqStatus, 32'hFFFF_FFD0);
    descValid = '1; frameTick = 1; cyc(); frameTick = 0;
    chk("R4 re-armed endpoint fires", reqStatus, 32'hFFFF_FFF0);
    cyc();
    chk("R6 fetch one edge later", fetchStrobe, 32'h20);
    chk("R6 request drops on service", reqStatus, 32'hFFFF_FFD0);
    chk("R6 no eot on service", eotFlag, '0);
    chk("R6 no flush on first fetch", flushStrobe, '0);

    // dropped transaction
    frameTick = 1; cyc(); frameTick = 0; cyc();
    chk("R7 refetch", fetchStrobe, 32'h20);
    chk("R7 flush stale buffer", flushStrobe, 32'h20);

    // completion
    xferDone = 32'h20; cyc(); xferDone = '0;
    chk("R8 eot on completion", eotFlag, 32'h20);
    eotMask = '0; #1;
    chk("R9 irq masked", {31'd0, eotIrq}, '0);
    eotMask = 32'h20; #1;
    chk("R9 irq unmasked", {31'd0, eotIrq}, 32'd1);
    xferDone = 32'h40; cyc(); xferDone = '0;
    chk("R8 done without transfer ignored", eotFlag, 32'h20);
    eotClr = 32'h20; cyc(); eotClr = '0;
    chk("R9 eot cleared", eotFlag, '0);
    chk("R9 irq falls", {31'd0, eotIrq}, '0);

    // clear and tick in the same cycle
    reqClr = 32'h40; frameTick = 1; cyc(); reqClr = '0; frameTick = 0;
    chk("R5 clear wins over tick", reqStatus, 32'hFFFF_FFB0);
    cyc();
    chk("R5 only ep5 fetched", fetchStrobe, 32'h20);
    chk("R7 no flush after completion", flushStrobe, '0);

    // software set
    reqClr = '1; cyc();
    reqClr = 32'h100; reqSet = 32'h100; cyc();
    chk("R10 clear wins over set", reqStatus, '0);
    reqClr = '0; reqSet = 32'h300; cyc(); reqSet = '0;
    chk("R10 set selected bits", reqStatus, 32'h300);
    cyc();
    chk("R10 set causes no fetch", fetchStrobe, '0);

    // mode select and DMA enable gating
    reqClr = '1; cyc(); reqClr = '0;
    dmaModeSel = ~32'h100; dmaEnable = ~32'h80;
    frameTick = 1; cyc(); frameTick = 0;
    chk("R1 mode select gates request", reqStatus, 32'hFFFF_FEF0);
    cyc();
    chk("R11 disabled endpoint not fetched", fetchStrobe, 32'hFFFF_FE70);
    chk("R11 disabled request stays latched", reqStatus, 32'h80);
    chk("R7 ep5 stale flush", flushStrobe, 32'h20);

    // random phase against the model
    rstN = 0; cyc(); rstN = 1;
    mReq = '0; mNew = '0; mAct = '0; mEot = '0;
    void'($urandom(32'd4177));
    for (int c = 0; c < 4000; c++) begin
      frameTick  = ($urandom % 4) == 0;
      dmaModeSel = ~($urandom & $urandom & $urandom);
      dmaEnable  = ~($urandom & $urandom & $urandom);
      descValid  = $urandom | $urandom;
      xferDone   = $urandom & $urandom;
      reqClr     = (($urandom % 3) == 0) ? ($urandom & $urandom) : '0;
      reqSet     = (($urandom % 16) == 0) ? ($urandom & $urandom & $urandom) : '0;
      eotClr     = (($urandom % 4) == 0) ? $urandom : '0;
      eotMask    = $urandom;
      @(posedge clk);
      modelStep();
      #1;
      chk("R1 R2 R4 R5 R10 random reqStatus", reqStatus, mReq);
      chk("R3 R6 R11 random fetch", fetchStrobe, mFetch);
      chk("R7 random flush", flushStrobe, mFlush);
      chk("R8 random eot", eotFlag, mEot);
      chk("R9 random irq", {31'd0, eotIrq}, {31'd0, |(mEot & eotMask)});
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule